// File: doc/BRIEF.md
# Status Flags and Branch Decision Unit

This block keeps the eight condition flags of a small processor core and decides the outcome of conditional branches. One command is presented per clock on `op_i`. The commands are:

- an ALU flag update, written under a per-bit mask;
- forcing a single flag high or low, chosen by a 3-bit index;
- moving one register bit into the transfer flag T, or writing T back into a chosen register bit;
- the return-from-interrupt side effect, which raises the interrupt-enable flag;
- a branch evaluation.

A branch tests either one flag, chosen by index, against a wanted polarity, or the signed relation N XOR V against that polarity. It returns three results:

- whether the branch is taken;
- the next program counter: PC + offset + 1 when taken, PC + 1 otherwise;
- how many cycles the branch costs.

The flag register sits in a two-process loop: the next value is computed combinationally and stored at the clock edge. Every result appears on the outputs one clock after its command is sampled. Decode, fetch, the register file and the stack live outside this block. The block receives the register byte on `reg_i` and hands back the modified byte on `ld_data_o`.

Top module: `flag_branch_unit`

## Requirements
- R1: After reset every flag bit of `status_o` is 0, and `br_valid_o` and `ld_valid_o` are 0.
- R2: Flag positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0. Opcode 2 (force high) with index s sets bit s of the flag register and leaves the other seven bits unchanged.
- R3: Opcode 3 (force low) with index s clears bit s only.
- R4: Opcode 1 (ALU update) copies `alu_flags_i[i]` into every flag i whose `alu_mask_i[i]` is 1, except S, and keeps every flag whose mask bit is 0. When mask bit N (2) or V (3) is 1, S becomes the new N XOR the new V. Otherwise S follows its own mask bit (4).
- R5: Opcode 4 (bit store) copies `reg_i[idx_i]` into T (bit 6) and changes no other flag.
- R6: Opcode 5 (bit load) returns `reg_i` with bit `idx_i` replaced by T on `ld_data_o`, raises `ld_valid_o` for one cycle, and leaves all flags unchanged.
- R7: Opcode 6 (interrupt return) sets I (bit 7) and keeps the other flags.
- R8: Opcode 7 with `br_signed_i`=0 takes the branch when flag `idx_i` equals `br_pol_i`. Same-or-higher is index 0 with polarity 0, and lower is index 0 with polarity 1.
- R9: With `br_signed_i`=1 the branch tests N XOR V and ignores S. Polarity 0 (greater-or-equal) is taken when N XOR V is 0, and polarity 1 (less-than) is taken when it is 1.
- R10: `br_next_pc_o` is `pc_i` + sign-extended 7-bit `off_i` + 1 when taken, and `pc_i` + 1 when not taken, modulo 2^PC_W.
- R11: `br_cycles_o` is 2 for a taken branch and 1 for a branch not taken.
- R12: Results appear one clock after the command. `br_valid_o` and `ld_valid_o` pulse only for their own opcodes. Opcode 0 and opcode 7 leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Command code (0 idle … 7 branch) |
| idx_i | input | 3 | Flag index or register bit index |
| alu_mask_i | input | 8 | Which flags the ALU update writes |
| alu_flags_i | input | 8 | New flag values from the ALU |
| reg_i | input | 8 | Register byte for bit store / bit load |
| br_pol_i | input | 1 | Wanted condition value for a branch |
| br_signed_i | input | 1 | Branch on N XOR V instead of a single flag |
| pc_i | input | PC_W | Current program counter |
| off_i | input | 7 | Signed branch offset |
| status_o | output | 8 | Flag register |
| ld_data_o | output | 8 | Register byte with T written in |
| ld_valid_o | output | 1 | `ld_data_o` is fresh |
| br_valid_o | output | 1 | Branch results are fresh |
| br_taken_o | output | 1 | Branch condition held |
| br_next_pc_o | output | PC_W | Next program counter |
| br_cycles_o | output | 2 | Cycle cost of the branch |

## Verification
Every result, whether a flag change, a bit-load byte or a branch decision, is due exactly one rising edge after its command is sampled. Inputs are driven on the falling edge, and the outputs are compared at the next falling edge, after the capturing rising edge. That compare runs against a reference model advanced once per command, so each clock compares the previous command's effect. Branch decisions read the flags as they stood before the branch command. The directed part deliberately leaves S disagreeing with N XOR V, so that a signed branch wired to S would be caught.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

    localparam int unsigned SR_W  = 8;
    localparam int unsigned IDX_W = 3;

    // flag positions; branch indices and the bit-load path depend on them
    localparam int unsigned BIT_C = 0;
    localparam int unsigned BIT_Z = 1;
    localparam int unsigned BIT_N = 2;
    localparam int unsigned BIT_V = 3;
    localparam int unsigned BIT_S = 4;
    localparam int unsigned BIT_H = 5;
    localparam int unsigned BIT_T = 6;
    localparam int unsigned BIT_I = 7;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_ALU    = 3'd1,
        OP_SET    = 3'd2,
        OP_CLR    = 3'd3,
        OP_TSTORE = 3'd4,
        OP_TLOAD  = 3'd5,
        OP_IRET   = 3'd6,
        OP_BRANCH = 3'd7
    } fbu_op_e;

endpackage

// File: rtl/fbu_alu_merge.sv
module fbu_alu_merge
    import fbu_pkg::*;
(
    input  logic [SR_W-1:0] sreg_i,
    input  logic [SR_W-1:0] mask_i,
    input  logic [SR_W-1:0] val_i,
    output logic [SR_W-1:0] merged_o
);
    logic n_new;
    logic v_new;
    logic nv_touched;

    assign n_new      = mask_i[BIT_N] ? val_i[BIT_N] : sreg_i[BIT_N];
    assign v_new      = mask_i[BIT_V] ? val_i[BIT_V] : sreg_i[BIT_V];
    assign nv_touched = mask_i[BIT_N] | mask_i[BIT_V];

    for (genvar g = 0; g < SR_W; g++) begin : g_bit
        if (g == BIT_S) begin : g_sign
            // sign flag tracks N^V whenever either source is rewritten
            assign merged_o[g] = nv_touched ? (n_new ^ v_new)
                               : (mask_i[g] ? val_i[g] : sreg_i[g]);
        end else begin : g_plain
            assign merged_o[g] = mask_i[g] ? val_i[g] : sreg_i[g];
        end
    end
endmodule

// File: rtl/fbu_cond.sv
module fbu_cond
    import fbu_pkg::*;
(
    input  logic [SR_W-1:0]  sreg_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             want_i,
    input  logic             signed_i,
    output logic             hold_o
);
    logic picked;
    logic lt_rel;
    logic tested;

    assign picked = sreg_i[idx_i];
    assign lt_rel = sreg_i[BIT_N] ^ sreg_i[BIT_V];
    assign tested = signed_i ? lt_rel : picked;
    assign hold_o = (tested == want_i);
endmodule

// File: rtl/fbu_pc_step.sv
module fbu_pc_step #(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFF_W = 7
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             take_i,
    output logic [PC_W-1:0]  next_o
);
    localparam int unsigned EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] add_term;

    assign off_ext  = {{EXT_W{off_i[OFF_W-1]}}, off_i};
    assign add_term = take_i ? off_ext : '0;
    assign next_o   = pc_i + add_term + PC_W'(1);
endmodule

// File: rtl/fbu_bit_xfer.sv
module fbu_bit_xfer
    import fbu_pkg::*;
(
    input  logic [SR_W-1:0]  reg_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             t_i,
    output logic             t_from_reg_o,
    output logic [SR_W-1:0]  reg_with_t_o
);
    assign t_from_reg_o = reg_i[idx_i];

    always_comb begin
        reg_with_t_o        = reg_i;
        reg_with_t_o[idx_i] = t_i;
    end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
    import fbu_pkg::*;
#(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFF_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [2:0]       idx_i,
    input  logic [7:0]       alu_mask_i,
    input  logic [7:0]       alu_flags_i,
    input  logic [7:0]       reg_i,
    input  logic             br_pol_i,
    input  logic             br_signed_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [7:0]       status_o,
    output logic [7:0]       ld_data_o,
    output logic             ld_valid_o,
    output logic             br_valid_o,
    output logic             br_taken_o,
    output logic [PC_W-1:0]  br_next_pc_o,
    output logic [1:0]       br_cycles_o
);
    typedef struct packed {
        logic [SR_W-1:0] sreg;
        logic [SR_W-1:0] ld_data;
        logic            ld_valid;
        logic            br_valid;
        logic            br_taken;
        logic [PC_W-1:0] br_pc;
        logic [1:0]      br_cycles;
    } fbu_state_t;

    fbu_state_t st_d, st_q;
    fbu_op_e    op;

    logic [SR_W-1:0] alu_merged;
    logic            cond_hold;
    logic [PC_W-1:0] pc_next;
    logic            t_from_reg;
    logic [SR_W-1:0] reg_with_t;

    assign op = fbu_op_e'(op_i);

    fbu_alu_merge u_merge (
        .sreg_i   (st_q.sreg),
        .mask_i   (alu_mask_i),
        .val_i    (alu_flags_i),
        .merged_o (alu_merged)
    );

    fbu_cond u_cond (
        .sreg_i   (st_q.sreg),
        .idx_i    (idx_i),
        .want_i   (br_pol_i),
        .signed_i (br_signed_i),
        .hold_o   (cond_hold)
    );

    fbu_pc_step #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
        .pc_i   (pc_i),
        .off_i  (off_i),
        .take_i (cond_hold),
        .next_o (pc_next)
    );

    fbu_bit_xfer u_xfer (
        .reg_i        (reg_i),
        .idx_i        (idx_i),
        .t_i          (st_q.sreg[BIT_T]),
        .t_from_reg_o (t_from_reg),
        .reg_with_t_o (reg_with_t)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ld_valid = 1'b0;
        st_d.br_valid = 1'b0;
        unique case (op)
            OP_ALU:    st_d.sreg = alu_merged;
            OP_SET:    st_d.sreg[idx_i] = 1'b1;
            OP_CLR:    st_d.sreg[idx_i] = 1'b0;
            OP_TSTORE: st_d.sreg[BIT_T] = t_from_reg;
            OP_TLOAD: begin
                st_d.ld_data  = reg_with_t;
                st_d.ld_valid = 1'b1;
            end
            OP_IRET:   st_d.sreg[BIT_I] = 1'b1;
            OP_BRANCH: begin
                st_d.br_valid  = 1'b1;
                st_d.br_taken  = cond_hold;
                st_d.br_pc     = pc_next;
                st_d.br_cycles = cond_hold ? 2'd2 : 2'd1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o     = st_q.sreg;
    assign ld_data_o    = st_q.ld_data;
    assign ld_valid_o   = st_q.ld_valid;
    assign br_valid_o   = st_q.br_valid;
    assign br_taken_o   = st_q.br_taken;
    assign br_next_pc_o = st_q.br_pc;
    assign br_cycles_o  = st_q.br_cycles;
endmodule

// File: rtl/fbu_checker.sv
module fbu_checker
    import fbu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op_i,
    input logic [2:0] idx_i,
    input logic       nv_upd,
    input logic       br_pol_i,
    input logic       br_signed_i,
    input logic [7:0] status_o,
    input logic       ld_valid_o,
    input logic       br_valid_o,
    input logic       br_taken_o,
    input logic [1:0] br_cycles_o
);
    a_r2_set_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_SET |=> status_o == ($past(status_o) | (8'd1 << $past(idx_i))));

    a_r3_clear_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_CLR |=> status_o == ($past(status_o) & ~(8'd1 << $past(idx_i))));

    a_r4_sign_tracks_nv: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ALU && nv_upd) |=> status_o[BIT_S] == (status_o[BIT_N] ^ status_o[BIT_V]));

    a_r6_load_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_TLOAD |=> $stable(status_o) && ld_valid_o);

    a_r7_iret_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_IRET |=> status_o[BIT_I]);

    a_r8_flag_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_BRANCH && !br_signed_i && status_o[idx_i] == br_pol_i) |=> br_taken_o);

    a_r9_signed_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_BRANCH && br_signed_i
         && (status_o[BIT_N] ^ status_o[BIT_V]) == br_pol_i) |=> br_taken_o);

    a_r11_cycle_cost: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid_o |-> br_cycles_o == (br_taken_o ? 2'd2 : 2'd1));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({br_valid_o, ld_valid_o}));

    a_r12_branch_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_BRANCH |=> $stable(status_o) && br_valid_o);
endmodule

bind flag_branch_unit fbu_checker u_fbu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .idx_i       (idx_i),
    .nv_upd      (alu_mask_i[2] | alu_mask_i[3]),
    .br_pol_i    (br_pol_i),
    .br_signed_i (br_signed_i),
    .status_o    (status_o),
    .ld_valid_o  (ld_valid_o),
    .br_valid_o  (br_valid_o),
    .br_taken_o  (br_taken_o),
    .br_cycles_o (br_cycles_o)
);

// File: tb/flag_branch_unit_test.sv
`timescale 1ns/1ps
module flag_branch_unit_test;
    localparam int PC_W = 16;
    localparam int OFF_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       op_i = '0;
    logic [2:0]       idx_i = '0;
    logic [7:0]       alu_mask_i = '0;
    logic [7:0]       alu_flags_i = '0;
    logic [7:0]       reg_i = '0;
    logic             br_pol_i = 1'b0;
    logic             br_signed_i = 1'b0;
    logic [PC_W-1:0]  pc_i = '0;
    logic [OFF_W-1:0] off_i = '0;
    logic [7:0]       status_o;
    logic [7:0]       ld_data_o;
    logic             ld_valid_o;
    logic             br_valid_o;
    logic             br_taken_o;
    logic [PC_W-1:0]  br_next_pc_o;
    logic [1:0]       br_cycles_o;

    always #2 clk = ~clk;

    flag_branch_unit #(.PC_W(PC_W), .OFF_W(OFF_W)) uut (.*);

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [7:0]      m_sreg = '0;
    logic [7:0]      e_ld = '0;
    bit              e_ldv = 0;
    bit              e_brv = 0;
    bit              e_taken = 0;
    logic [PC_W-1:0] e_pc = '0;
    int              e_cyc = 0;
    string           e_tag = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(status_o == m_sreg, e_tag, "status", status_o, m_sreg);
        chk(ld_valid_o == e_ldv, "R12", "ld_valid", ld_valid_o, e_ldv);
        chk(br_valid_o == e_brv, "R12", "br_valid", br_valid_o, e_brv);
        if (e_ldv) chk(ld_data_o == e_ld, "R6", "ld_data", ld_data_o, e_ld);
        if (e_brv) begin
            chk(br_taken_o == e_taken, e_tag, "taken", br_taken_o, e_taken);
            chk(br_next_pc_o == e_pc, "R10", "next_pc", br_next_pc_o, e_pc);
            chk(int'(br_cycles_o) == e_cyc, "R11", "cycles", br_cycles_o, e_cyc);
        end
    endtask

    task automatic step(input int op, input int idx, input logic [7:0] mask,
                        input logic [7:0] flg, input logic [7:0] rg,
                        input bit pol, input bit sgn,
                        input logic [PC_W-1:0] pc, input logic [OFF_W-1:0] off);
        logic [7:0] nx;
        bit nv;
        bit test;
        @(negedge clk);
        compare();
        op_i = 3'(op); idx_i = 3'(idx); alu_mask_i = mask; alu_flags_i = flg;
        reg_i = rg; br_pol_i = pol; br_signed_i = sgn; pc_i = pc; off_i = off;
        nx = m_sreg; e_ldv = 0; e_brv = 0;
        case (op)
            1: begin
                e_tag = "R4";
                for (int i = 0; i < 8; i++) if (i != 4 && mask[i]) nx[i] = flg[i];
                if (mask[2] || mask[3]) nx[4] = nx[2] ^ nx[3];
                else if (mask[4]) nx[4] = flg[4];
            end
            2: begin e_tag = "R2"; nx[idx] = 1'b1; end
            3: begin e_tag = "R3"; nx[idx] = 1'b0; end
            4: begin e_tag = "R5"; nx[6] = rg[idx]; end
            5: begin e_tag = "R6"; e_ld = rg; e_ld[idx] = m_sreg[6]; e_ldv = 1; end
            6: begin e_tag = "R7"; nx[7] = 1'b1; end
            7: begin
                nv = m_sreg[2] ^ m_sreg[3];
                test = sgn ? nv : m_sreg[idx];
                e_tag = sgn ? "R9" : "R8";
                e_brv = 1;
                e_taken = (test == pol);
                e_cyc = e_taken ? 2 : 1;
                e_pc = e_taken ? PC_W'(int'(pc) + int'($signed(off)) + 1)
                               : PC_W'(int'(pc) + 1);
            end
            default: e_tag = "R12";
        endcase
        m_sreg = nx;
    endtask

    task automatic idle();
        step(0, 0, 8'h00, 8'h00, 8'h00, 0, 0, '0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state is compared on the first step
        idle();
        idle();
        // R2 / R3: force each index high, then low
        for (int i = 0; i < 8; i++) step(2, i, 0, 0, 0, 0, 0, '0, '0);
        for (int i = 0; i < 8; i++) step(3, i, 0, 0, 0, 0, 0, '0, '0);
        // R4: ALU masks including S derivation
        step(1, 0, 8'h04, 8'h04, 0, 0, 0, '0, '0);
        step(1, 0, 8'h0C, 8'h0C, 0, 0, 0, '0, '0);
        step(1, 0, 8'h10, 8'h10, 0, 0, 0, '0, '0);
        step(1, 0, 8'h1B, 8'hE3, 0, 0, 0, '0, '0);
        step(1, 0, 8'hFF, 8'h5A, 0, 0, 0, '0, '0);
        // R5 / R6: bit transfer
        step(4, 3, 0, 0, 8'h08, 0, 0, '0, '0);
        step(5, 0, 0, 0, 8'h00, 0, 0, '0, '0);
        step(4, 7, 0, 0, 8'h7F, 0, 0, '0, '0);
        step(5, 5, 0, 0, 8'hFF, 0, 0, '0, '0);
        // R7: interrupt return
        step(3, 7, 0, 0, 0, 0, 0, '0, '0);
        step(6, 0, 0, 0, 0, 0, 0, '0, '0);
        // R8: every flag, both polarities
        for (int i = 0; i < 8; i++) begin
            step(7, i, 0, 0, 0, 0, 0, 16'h0100, 7'h05);
            step(7, i, 0, 0, 0, 1, 0, 16'h0100, 7'h7B);
        end
        // R9: S forced to disagree with N^V
        step(2, 2, 0, 0, 0, 0, 0, '0, '0);
        step(3, 3, 0, 0, 0, 0, 0, '0, '0);
        step(3, 4, 0, 0, 0, 0, 0, '0, '0);
        step(7, 0, 0, 0, 0, 1, 1, 16'h0200, 7'h10);
        step(7, 0, 0, 0, 0, 0, 1, 16'h0200, 7'h10);
        step(2, 3, 0, 0, 0, 0, 0, '0, '0);
        step(2, 4, 0, 0, 0, 0, 0, '0, '0);
        step(7, 0, 0, 0, 0, 0, 1, 16'h0200, 7'h10);
        step(7, 0, 0, 0, 0, 1, 1, 16'h0200, 7'h10);
        // R10: wrap and most-negative offset
        step(2, 0, 0, 0, 0, 0, 0, '0, '0);
        step(7, 0, 0, 0, 0, 1, 0, 16'hFFFF, 7'h00);
        step(7, 0, 0, 0, 0, 1, 0, 16'h0010, 7'h40);
        step(7, 0, 0, 0, 0, 1, 0, 16'hFFF0, 7'h3F);
        step(7, 0, 0, 0, 0, 0, 0, 16'hFFFF, 7'h3F);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            step(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                 8'($urandom), 8'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom), PC_W'($urandom), OFF_W'($urandom));
        end
        idle();
        idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule